// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets clocked logic use an external asynchronous static RAM. The RAM has an 18-bit address and a 4-bit bidirectional data bus. On the user side the block takes a valid/ready request that carries a read/write flag, an address and write data. It returns read data with a one-cycle valid pulse. On the memory side it drives active-low chip select, write enable and output enable, plus the address lines. The data bus is split into an output value, an enable for the controller's own drivers and an input value. The pad or board-level tri-state buffer joins these three.

All memory-side outputs come from flops, so the strobes do not glitch. The length of each phase is a count of clock cycles fixed at elaboration: the read access window, the write-pulse width and the read-to-idle turnaround. The address register loads only in the cycle a request is accepted, and all strobes are inactive in that cycle. Output enable stays inactive for the whole of every write. The controller's data drivers never switch on in the cycle right after the memory was driving the bus.

Top module: `asram_bus_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, mem_cs_n, mem_we_n and mem_oe_n are high, mem_dq_oe is low, rsp_valid is low and req_ready is high.
- R2: In the cycle after a read is accepted (req_valid and req_ready high with req_write low at a clock edge), mem_cs_n and mem_oe_n go low, mem_we_n stays high and mem_dq_oe stays low. This lasts exactly RD_CYCLES cycles, and mem_addr holds the accepted address throughout.
- R3: rsp_valid is high for exactly one cycle, the cycle right after the last read access cycle. In that cycle rsp_rdata equals mem_dq_i as sampled at the clock edge that ends the last access cycle.
- R4: After a write is accepted (req_write high), the bus goes through four steps:
  - one setup cycle with mem_cs_n low, mem_we_n high and mem_dq_oe low;
  - then WR_CYCLES cycles with mem_cs_n and mem_we_n low, mem_dq_oe high and mem_dq_o equal to the accepted data;
  - then one release cycle with all strobes high, the drivers still on and the address unchanged;
  - then mem_dq_oe low from the next cycle.
- R5: mem_oe_n is high in every cycle in which mem_we_n is low or mem_dq_oe is high.
- R6: mem_addr changes only at a clock edge that ends a cycle in which mem_cs_n was high. In particular, it never changes while mem_cs_n and mem_we_n are both low.
- R7: After the last read access cycle, all strobes are high and req_ready is low for exactly TURN_CYCLES cycles. mem_dq_oe is never high in the cycle right after a cycle with mem_oe_n low.
- R8: When req_ready is high, all strobes are high and mem_dq_oe is low. req_ready is low from the cycle after an acceptance until the sequence ends: RD_CYCLES+TURN_CYCLES cycles for a read, WR_CYCLES+2 cycles for a write.
- R9: A read of an address returns the data last written to that address. This holds for back-to-back writes, back-to-back reads and alternating write/read and read/write pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read-data-valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_i | input | DATA_W | Data from the memory pins |

## Verification
A wrong sequencer state or timer count shows up at the strobe pins in the very next cycle. It shows as a strobe phase that is one cycle too long or too short, as drivers that are on while output enable is low, or as the read pulse or ready arriving a cycle early or late. The bench checks each of these at the exact cycle it expects them. Its memory model drives wrong data until the read has been active for the full access window, so a capture that comes one cycle early returns wrong data at once. A stale address or data register shows up only later, as a wrong value when that location is read back during the write-then-read sweeps.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_READ   = 3'd1,
      ST_TURN   = 3'd2,
      ST_WSETUP = 3'd3,
      ST_WPULSE = 3'd4,
      ST_WREL   = 3'd5
   } asram_state_e;

   typedef struct packed {
      logic cs_n;
      logic we_n;
      logic oe_n;
      logic dq_oe;
      logic ready;
   } asram_pins_t;

   localparam asram_pins_t PINS_QUIET = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                          dq_oe: 1'b0, ready: 1'b1};

   function automatic asram_pins_t pins_for(input asram_state_e s);
      asram_pins_t p;
      p.cs_n  = !(s inside {ST_READ, ST_WSETUP, ST_WPULSE});
      p.we_n  = !(s == ST_WPULSE);
      p.oe_n  = !(s == ST_READ);
      p.dq_oe = (s inside {ST_WPULSE, ST_WREL});
      p.ready = (s == ST_IDLE);
      return p;
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/asram_cycle_timer.sv
module asram_cycle_timer #(
   parameter int unsigned LIMIT = 3,
   localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   generate
      if (LIMIT <= 1) begin : g_no_count
         logic unused_tmr;
         assign unused_tmr = ^{clk, rst_n, load, load_val};
         assign zero = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= load_val;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign zero = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int unsigned RD_CYCLES   = 3,
   parameter int unsigned WR_CYCLES   = 2,
   parameter int unsigned TURN_CYCLES = 1,
   parameter int unsigned CNT_W       = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tmr_zero,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             accept,
   output logic             capture,
   output asram_state_e     nxt_state
);

   asram_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= nxt_state;
      end
   end

   always_comb begin
      nxt_state = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      accept    = 1'b0;
      capture   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               if (req_write) begin
                  nxt_state = ST_WSETUP;
               end else begin
                  nxt_state = ST_READ;
                  tmr_load  = 1'b1;
                  tmr_val   = CNT_W'(RD_CYCLES - 1);
               end
            end
         end
         ST_READ: begin
            if (tmr_zero) begin
               capture   = 1'b1;
               nxt_state = ST_TURN;
               tmr_load  = 1'b1;
               tmr_val   = CNT_W'(TURN_CYCLES - 1);
            end
         end
         ST_TURN: begin
            if (tmr_zero) nxt_state = ST_IDLE;
         end
         ST_WSETUP: begin
            nxt_state = ST_WPULSE;
            tmr_load  = 1'b1;
            tmr_val   = CNT_W'(WR_CYCLES - 1);
         end
         ST_WPULSE: begin
            if (tmr_zero) nxt_state = ST_WREL;
         end
         ST_WREL: begin
            nxt_state = ST_IDLE;
         end
         default: begin
            nxt_state = ST_IDLE;
         end
      endcase
   end

endmodule

// File: rtl/asram_pin_regs.sv
module asram_pin_regs
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  asram_state_e      nxt_state,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_i,
   output asram_pins_t       pins,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pins <= PINS_QUIET;
      end else begin
         pins <= pins_for(nxt_state);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dq_o <= '0;
      end else if (accept) begin
         mem_addr <= req_addr;
         mem_dq_o <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= mem_dq_i;
      end
   end

endmodule

// File: rtl/asram_bus_ctrl.sv
module asram_bus_ctrl
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W      = 18,
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned RD_CYCLES   = 3,
   parameter int unsigned WR_CYCLES   = 2,
   parameter int unsigned TURN_CYCLES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int unsigned MAX_CYC = max3(RD_CYCLES, WR_CYCLES, TURN_CYCLES);
   localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   generate
      if (RD_CYCLES < 1 || WR_CYCLES < 1 || TURN_CYCLES < 1) begin : g_bad_timing
         $error("asram_bus_ctrl: every phase needs at least one cycle");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asram_bus_ctrl: address and data widths must be nonzero");
      end
   endgenerate

   logic             tmr_zero;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             accept;
   logic             capture;
   asram_state_e     nxt_state;
   asram_pins_t      pins;

   asram_cycle_timer #(
      .LIMIT (MAX_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   asram_seq #(
      .RD_CYCLES   (RD_CYCLES),
      .WR_CYCLES   (WR_CYCLES),
      .TURN_CYCLES (TURN_CYCLES),
      .CNT_W       (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .tmr_zero  (tmr_zero),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .accept    (accept),
      .capture   (capture),
      .nxt_state (nxt_state)
   );

   asram_pin_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .nxt_state (nxt_state),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_dq_i  (mem_dq_i),
      .pins      (pins),
      .mem_addr  (mem_addr),
      .mem_dq_o  (mem_dq_o),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   assign mem_cs_n  = pins.cs_n;
   assign mem_we_n  = pins.we_n;
   assign mem_oe_n  = pins.oe_n;
   assign mem_dq_oe = pins.dq_oe;
   assign req_ready = pins.ready;

endmodule

// File: rtl/asram_bus_ctrl_chk.sv
module asram_bus_ctrl_chk #(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned DATA_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_cs_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_dq_oe
);

   logic unused_chk;
   assign unused_chk = ^DATA_W;

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid && req_ready));

   p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_we_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_dq_oe));

   p_we_after_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(!mem_cs_n));

   p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

   p_addr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mem_addr) |-> $past(mem_cs_n));

   p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!mem_oe_n) |-> !mem_dq_oe);

   p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

bind asram_bus_ctrl asram_bus_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/asram_bus_ctrl_test.sv
module asram_bus_ctrl_test;

   localparam int unsigned AW = 18;
   localparam int unsigned DW = 4;
   localparam int unsigned RD = 3;
   localparam int unsigned WR = 2;
   localparam int unsigned TN = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_o;
   logic [DW-1:0] mem_dq_i = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   asram_bus_ctrl #(
      .ADDR_W (AW), .DATA_W (DW),
      .RD_CYCLES (RD), .WR_CYCLES (WR), .TURN_CYCLES (TN)
   ) uut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n),
      .mem_addr (mem_addr), .mem_dq_o (mem_dq_o), .mem_dq_oe (mem_dq_oe),
      .mem_dq_i (mem_dq_i)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [AW-1:0] addr_of(input int i);
      logic [7:0] b;
      b = 8'(i);
      return {~b, 2'b01, b};
   endfunction

   function automatic logic [DW-1:0] data_of(input int i);
      return DW'(i * 3 + (i >> 3));
   endfunction

   // memory model: data is wrong until the read has been active RD cycles
   logic [DW-1:0] model [0:1023];
   int            rd_age = 0;
   logic [AW-1:0] prev_addr = '0;
   bit            prev_wr = 1'b0;

   initial begin
      for (int k = 0; k < 1024; k++) model[k] = '0;
   end

   always @(negedge clk) begin
      bit rd_act;
      rd_act = !mem_cs_n && !mem_oe_n && mem_we_n;
      if (!mem_cs_n && !mem_we_n) model[mem_addr[9:0]] <= mem_dq_oe ? mem_dq_o : '0;
      if (rd_act) rd_age = rd_age + 1; else rd_age = 0;
      mem_dq_i <= (rd_act && rd_age >= RD) ? model[mem_addr[9:0]] : ~model[mem_addr[9:0]];
      if (rst_n && !done) begin
         chk("R5", "oe low during write drive", int'(!mem_oe_n && (!mem_we_n || mem_dq_oe)), 0);
         chk("R7", "bus contention", int'(rd_act && mem_dq_oe), 0);
         chk("R6", "address moved in write overlap",
             int'((prev_wr || (!mem_cs_n && !mem_we_n)) && mem_addr != prev_addr), 0);
      end
      prev_addr = mem_addr;
      prev_wr   = !mem_cs_n && !mem_we_n;
   end

   // called just after a falling edge, returns just after a falling edge
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R4", "setup cs_n", int'(mem_cs_n), 0);
      chk("R4", "setup we_n", int'(mem_we_n), 1);
      chk("R4", "setup dq_oe", int'(mem_dq_oe), 0);
      chk("R8", "busy ready", int'(req_ready), 0);
      chk("R6", "write addr", int'(mem_addr), int'(a));
      for (int k = 0; k < int'(WR); k++) begin
         @(negedge clk);
         chk("R4", "pulse we_n", int'(mem_we_n), 0);
         chk("R4", "pulse cs_n", int'(mem_cs_n), 0);
         chk("R4", "pulse dq_oe", int'(mem_dq_oe), 1);
         chk("R4", "pulse data", int'(mem_dq_o), int'(d));
         chk("R5", "pulse oe_n", int'(mem_oe_n), 1);
      end
      @(negedge clk);
      chk("R4", "release strobes", int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
      chk("R4", "release dq_oe", int'(mem_dq_oe), 1);
      chk("R6", "release addr", int'(mem_addr), int'(a));
      chk("R8", "release ready", int'(req_ready), 0);
      @(negedge clk);
      chk("R4", "drivers off", int'(mem_dq_oe), 0);
      chk("R8", "write done ready", int'(req_ready), 1);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = ~e;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      for (int k = 1; k <= int'(RD); k++) begin
         @(negedge clk);
         req_valid = 1'b0;
         chk("R2", "access strobes", int'({mem_cs_n, mem_oe_n, mem_we_n}), 1);
         chk("R2", "access dq_oe", int'(mem_dq_oe), 0);
         chk("R2", "access addr", int'(mem_addr), int'(a));
         chk("R3", "early rsp_valid", int'(rsp_valid), 0);
         chk("R8", "access ready", int'(req_ready), 0);
      end
      @(negedge clk);
      chk("R3", "rsp_valid", int'(rsp_valid), 1);
      chk("R9", "read data", int'(rsp_rdata), int'(e));
      chk("R7", "turn strobes", int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
      chk("R7", "turn dq_oe", int'(mem_dq_oe), 0);
      chk("R7", "turn ready", int'(req_ready), 0);
      for (int k = 2; k <= int'(TN); k++) begin
         @(negedge clk);
         chk("R3", "pulse length", int'(rsp_valid), 0);
         chk("R7", "turn strobes", int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
         chk("R7", "turn ready", int'(req_ready), 0);
      end
      @(negedge clk);
      chk("R3", "pulse end", int'(rsp_valid), 0);
      chk("R7", "ready after turn", int'(req_ready), 1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1", "reset strobes", int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
      chk("R1", "reset dq_oe", int'(mem_dq_oe), 0);
      chk("R1", "reset rsp_valid", int'(rsp_valid), 0);
      chk("R1", "reset ready", int'(req_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "post reset strobes", int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
      chk("R1", "post reset ready", int'(req_ready), 1);

      for (int i = 0; i < 256; i++) do_write(addr_of(i), data_of(i));
      for (int i = 0; i < 256; i++) do_read(addr_of(i), data_of(i));
      for (int i = 0; i < 64; i++) begin
         do_write(addr_of(i), ~data_of(i));
         do_read(addr_of(i), ~data_of(i));
         do_read(addr_of(i + 128), data_of(i + 128));
      end
      for (int i = 0; i < 64; i++) do_read(addr_of(i), ~data_of(i));
      finish_run();
   end

endmodule